// File: doc/BRIEF.md
# Symmetric Divide-by-Three Pixel Column Clock

This block derives a pixel-column signal at one third of a 16 MHz master rate with an exact 50% duty cycle. An odd ratio cannot give equal high and low times when only whole master periods are available. The block therefore runs from a single reference clock at twice the master rate, `clk2x`. It splits every master period into a first half, with the master level high, and a second half, with the master level low. A three-state preset counter steps through 13, 14 and 15 once per master period. It reloads 13 on the master period after it reaches its terminal count.

The column output `pix_col` toggles at two evenly spaced points in each counter cycle. One is the start of state 15, the terminal count. The other is the start of the second half of state 13, the only state with counter bit 1 low. Whenever counter bit 0 is low, the output is cleared. This locks the output into one phase: it goes low at the second half of state 13 and can never settle half a counter cycle late. A one-cycle strobe `col_strobe` marks every change of `pix_col`, which gives two strobes per three master periods. Downstream logic uses this strobe to advance a pixel shift register.

All flops use an asynchronous active-low reset. Reset is asserted at once and released through a short synchronizer.

Top module: `pix_clkdiv3`

## Requirements
- R1: While `rst_n` is low, `cnt_state` is 13, `mclk` is 1, `pix_col` is 1 and `col_strobe` is 0.
- R2: `cnt_state` only ever takes the values 13, 14 and 15. It changes only on a `clk2x` edge that ends a cycle with `mclk` low, and it steps 13 to 14, 14 to 15, and 15 to 13.
- R3: After reset is released, `mclk` inverts on every `clk2x` edge. The value 1 marks the first half of a master period and 0 marks the second half.
- R4: `pix_col` has a period of exactly 6 `clk2x` cycles, which is 3 master periods. It is high for exactly 3 consecutive cycles and low for exactly 3.
- R5: `pix_col` is 1 in both halves of state 15 and in the first half of state 13. It is 0 in the second half of state 13 and in both halves of state 14.
- R6: `pix_col` falls exactly when the block enters the second half of state 13 (`cnt_state` 13, `mclk` 0). It rises exactly when the block enters the first half of state 15 (`cnt_state` 15, `mclk` 1).
- R7: `col_strobe` is 1 for exactly those `clk2x` cycles in which `pix_col` differs from its value in the previous cycle. This gives two one-cycle strobes every 6 cycles.
- R8: An assertion of `rst_n` at any point in the sequence, including between clock edges, returns all outputs to the R1 state at once. After release, the same phase as after power-up resumes.
- R9: After `rst_n` rises, outputs hold the reset state for `SYNC_STAGES` rising `clk2x` edges. The next edge moves the block to the second half of state 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Reference clock at twice the master rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_col | output | 1 | Column clock at master/3, 50% duty |
| col_strobe | output | 1 | One-cycle pulse on every `pix_col` change |
| mclk | output | 1 | Master-period half indicator (1 first half, 0 second half) |
| cnt_state | output | CNT_W | Preset counter state (13, 14, 15 for CNT_W = 4) |

## Verification
Every output is a register clocked by `clk2x`. A change in state therefore shows on all four outputs one edge after it is decided, and the bench samples them on the falling edge that follows. After reset is released, the first change is due on rising edge `SYNC_STAGES`+1, and the bench counts those edges one by one. From then on, a six-slot model predicts each output every cycle. The high and low run lengths of `pix_col` are measured against 3 cycles. Reset asserted part-way through a clock cycle is checked one time step later, because it takes effect without waiting for an edge.

// File: rtl/pixdiv_pkg.sv
package pixdiv_pkg;

  // Which half of a master-clock period the sequencer is in.
  typedef enum logic {
    HALF_HI = 1'b0,   // first half: master level high
    HALF_LO = 1'b1    // second half: master level low
  } half_e;

endpackage

// File: rtl/pixdiv_rst_sync.sv
module pixdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sn = chain_q[STAGES-1];

endmodule

// File: rtl/pixdiv_phase_seq.sv
module pixdiv_phase_seq
  import pixdiv_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_sn,
  output logic [CNT_W-1:0] cnt_q,
  output half_e            half_q,
  output logic [CNT_W-1:0] cnt_d,
  output half_e            half_d
);

  localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LOAD = TERM - 2;

  logic adv_en;
  logic term_hit;

  // next-state
  always_comb begin
    adv_en   = (half_q == HALF_LO);
    term_hit = (cnt_q == TERM);
    half_d   = (half_q == HALF_HI) ? HALF_LO : HALF_HI;
    cnt_d    = cnt_q;
    if (adv_en) begin
      if (term_hit) cnt_d = LOAD;
      else          cnt_d = cnt_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q  <= LOAD;
      half_q <= HALF_HI;
    end else begin
      half_q <= half_d;
      if (adv_en) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pixdiv_toggle.sv
module pixdiv_toggle
  import pixdiv_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic [CNT_W-1:0] cnt_d,
  input  half_e            half_d,
  output logic             pix_q,
  output logic             strobe_q
);

  localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

  logic tog_term;
  logic tog_low13;
  logic clr_phase;
  logic pix_d;
  logic strobe_d;

  // next-state, decided from the slot being entered
  always_comb begin
    tog_term  = (cnt_d == TERM) && (half_d == HALF_HI);
    tog_low13 = !cnt_d[1] && (half_d == HALF_LO);
    clr_phase = !cnt_d[0];
    if (clr_phase)                   pix_d = 1'b0;
    else if (tog_term || tog_low13)  pix_d = !pix_q;
    else                             pix_d = pix_q;
    strobe_d  = pix_d ^ pix_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pix_q    <= 1'b1;
      strobe_q <= 1'b0;
    end else begin
      pix_q    <= pix_d;
      strobe_q <= strobe_d;
    end
  end

endmodule

// File: rtl/pix_clkdiv3.sv
module pix_clkdiv3
  import pixdiv_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk2x,
  input  logic             rst_n,
  output logic             pix_col,
  output logic             col_strobe,
  output logic             mclk,
  output logic [CNT_W-1:0] cnt_state
);

  logic             rst_s;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  half_e            half_q;
  half_e            half_d;

  pixdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk2x),
    .rst_n  (rst_n),
    .rst_sn (rst_s)
  );

  pixdiv_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk    (clk2x),
    .rst_sn (rst_s),
    .cnt_q  (cnt_q),
    .half_q (half_q),
    .cnt_d  (cnt_d),
    .half_d (half_d)
  );

  pixdiv_toggle #(.CNT_W(CNT_W)) u_tog (
    .clk      (clk2x),
    .rst_sn   (rst_s),
    .cnt_d    (cnt_d),
    .half_d   (half_d),
    .pix_q    (pix_col),
    .strobe_q (col_strobe)
  );

  assign cnt_state = cnt_q;
  assign mclk      = (half_q == HALF_HI);

endmodule

// File: rtl/pix_clkdiv3_chk.sv
module pix_clkdiv3_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             pix_col,
  input logic             col_strobe,
  input logic             mclk,
  input logic [CNT_W-1:0] cnt_state
);

  localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LOAD = TERM - 2;

  // R2
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (cnt_state == LOAD) || (cnt_state == LOAD + 1'b1) || (cnt_state == TERM));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !mclk |=> cnt_state == (($past(cnt_state) == TERM) ? LOAD : $past(cnt_state) + 1'b1));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    mclk |=> $stable(cnt_state));

  // R3
  half_alt_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    1'b1 |=> (mclk != $past(mclk)));

  // R5
  phase_map_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    pix_col == ((cnt_state == TERM) || ((cnt_state == LOAD) && mclk)));

  // R4
  high_len_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(pix_col) |=> pix_col ##1 pix_col ##1 !pix_col);

  // R4
  low_len_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(pix_col) |=> !pix_col ##1 !pix_col ##1 pix_col);

  // R7
  strobe_rise_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(pix_col) |-> col_strobe);

  // R7
  strobe_fall_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(pix_col) |-> col_strobe);

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    col_strobe |=> !col_strobe);

endmodule

bind pix_clkdiv3 pix_clkdiv3_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk2x),
  .rst_sn     (rst_s),
  .pix_col    (pix_col),
  .col_strobe (col_strobe),
  .mclk       (mclk),
  .cnt_state  (cnt_state)
);

// File: tb/sim_pix_clkdiv3.sv
module sim_pix_clkdiv3;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int SYNC       = 2;

  logic             clk2x;
  logic             rst_n;
  logic             pix_col;
  logic             col_strobe;
  logic             mclk;
  logic [CNT_W-1:0] cnt_state;

  int vectors;
  int fails;
  int slot;
  int run_len;
  bit run_valid;
  bit done;

  pix_clkdiv3 #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC)) u0 (
    .clk2x      (clk2x),
    .rst_n      (rst_n),
    .pix_col    (pix_col),
    .col_strobe (col_strobe),
    .mclk       (mclk),
    .cnt_state  (cnt_state)
  );

  initial clk2x = 1'b0;
  always #(CLK_PERIOD/2) clk2x = ~clk2x;

  // slots: 0=13 first half, 1=13 second, 2=14a, 3=14b, 4=15a, 5=15b
  function automatic int exp_cnt(int s);
    return (s < 2) ? 13 : (s < 4) ? 14 : 15;
  endfunction
  function automatic int exp_mclk(int s);
    return (s % 2 == 0) ? 1 : 0;
  endfunction
  function automatic int exp_pix(int s);
    return (s == 0 || s == 4 || s == 5) ? 1 : 0;
  endfunction
  function automatic int exp_strobe(int s);
    return (s == 1 || s == 4) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state(string req, int s);
    check({req, " cnt_state"}, int'(cnt_state), exp_cnt(s));
    check({req, " mclk"},      int'(mclk),      exp_mclk(s));
    check({req, " pix_col"},   int'(pix_col),   exp_pix(s));
    check({req, " strobe"},    int'(col_strobe), s == 0 ? 0 : exp_strobe(s));
  endtask

  task automatic step_slots(int n);
    for (int i = 0; i < n; i++) begin
      logic prev_pix;
      prev_pix = pix_col;
      @(posedge clk2x);
      slot = (slot + 1) % 6;
      @(negedge clk2x);
      check("R2", int'(cnt_state), exp_cnt(slot));
      check("R3", int'(mclk), exp_mclk(slot));
      check("R5", int'(pix_col), exp_pix(slot));
      check("R7", int'(col_strobe), exp_strobe(slot));
      if (pix_col != prev_pix) begin
        // R6: edge position against counter state
        if (pix_col) check("R6 rise state", int'(cnt_state) * 2 + int'(mclk), 15 * 2 + 1);
        else         check("R6 fall state", int'(cnt_state) * 2 + int'(mclk), 13 * 2 + 0);
        // R4: previous run length
        if (run_valid) check("R4 run length", run_len, 3);
        run_valid = 1'b1;
        run_len   = 1;
      end else begin
        run_len++;
      end
    end
  endtask

  task automatic release_reset();
    @(negedge clk2x);
    rst_n = 1'b1;
    for (int k = 0; k < SYNC; k++) begin
      @(posedge clk2x);
      @(negedge clk2x);
      check_state("R9 hold", 0);
    end
    slot      = 0;
    run_valid = 1'b0;
    run_len   = 0;
    step_slots(1);
    check("R9 first advance mclk", int'(mclk), 0);
  endtask

  task automatic sync_reset(int hold);
    @(negedge clk2x);
    rst_n = 1'b0;
    #1;
    check_state("R8 sync", 0);
    for (int k = 0; k < hold; k++) @(negedge clk2x);
    check_state("R1 held", 0);
    release_reset();
  endtask

  task automatic async_reset(int offset, int hold);
    @(posedge clk2x);
    #(offset);
    rst_n = 1'b0;
    #1;
    check_state("R8 async", 0);
    for (int k = 0; k < hold; k++) @(negedge clk2x);
    check_state("R1 held", 0);
    release_reset();
  endtask

  initial begin
    void'($urandom(32'h5eed_0d3));
    vectors = 0;
    fails   = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    slot    = 0;
    run_valid = 1'b0;
    run_len = 0;
    repeat (4) @(negedge clk2x);
    // R1: state under reset
    check_state("R1", 0);
    release_reset();
    step_slots(60);
    // directed: reset in each slot of the sequence
    for (int s = 0; s < 6; s++) begin
      step_slots(s + 6);
      sync_reset(1 + s);
      step_slots(18);
    end
    // random runs and resets
    for (int it = 0; it < 40; it++) begin
      step_slots(10 + int'($urandom % 300));
      if ($urandom % 2 == 0) sync_reset(1 + int'($urandom % 8));
      else async_reset(1 + int'($urandom % (CLK_PERIOD - 1)), 1 + int'($urandom % 8));
    end
    step_slots(120);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule